// File: doc/BRIEF.md
# Tile Video Controller Register Interface

This block is the processor-side register file of a tile-based video controller. A host drives an 8-bit data bus, a 3-bit register select and separate read and write strobes. Through these it programs a control byte, reads a status byte, sets horizontal and vertical scroll, and positions a 14-bit video memory pointer. A data port reads and writes video memory through that pointer. Reads on the data port are buffered, so each read hands back the byte fetched by the read before it. The display timing logic supplies a vertical-blank level, and the block latches its rising edge into the status byte.

Video memory below address 0x3F00 is reached through a simple synchronous port: the address and write enable are presented in the access cycle, and read data returns one cycle later. Addresses from 0x3F00 upward select a 32-entry palette. The palette is driven through a per-entry write-enable mask, and a write to a backdrop entry is copied to all eight backdrop slots. A separate byte-wide port fills sprite attribute memory through an auto-incrementing address. The decoded control fields and the scroll values, each also split into coarse and fine parts, are presented as plain outputs for the renderer.

Top module: `vdc_regs`

## Requirements
- R1: Writing register select 0 loads the control byte: bits [1:0] give `nt_sel`, bit 2 gives `inc32`, bit 3 gives `spr_base`, bit 4 gives `bg_base` and bit 5 gives `spr_tall`. Each output follows on the cycle after the write.
- R2: A read of select 2 returns `{vblank_flag, 7'b0}` on `rdata` in the read cycle. The same read clears the flag and the shared write toggle, so the next scroll or address write counts as a first write.
- R3: Writes to select 5 alternate. The first sets `scroll_x` and the second sets `scroll_y`, and a vertical value above 239 is stored as 0. The coarse outputs equal the value shifted right by 3, and the fine outputs equal its low 3 bits.
- R4: Writes to select 6 alternate. The first sets the pointer to `{wdata[5:0], 8'h00}`, and the second ORs `wdata` into the low byte. Writes to select 5 and select 6 share one toggle, and every such write flips it.
- R5: A read of select 7 returns the buffered byte in the read cycle. It then fetches from the current pointer into the buffer. Back-to-back data reads return the bytes of consecutive earlier fetches.
- R6: Every data-port read or write advances the pointer by 32 when `inc32` is set and by 1 otherwise, wrapping within 14 bits. `vmem_addr` always shows the pointer.
- R7: A data-port write below 0x3F00 asserts `vmem_we` and leaves `pal_we` at zero. At or above 0x3F00: a pointer with low 4 bits zero drives `pal_we` = 32'h1111_1111 (the eight backdrop slots 0x00, 0x04 … 0x1C). A pointer with low 2 bits nonzero drives the single bit `pal_we[ptr[4:0]]`. Any other palette address drives no enable at all.
- R8: A write to select 3 sets the sprite address. Each write to select 4 asserts `spr_we` with `wdata` at the current sprite address, and the address then increments with 8-bit wrap.
- R9: The vertical-blank flag is set on the cycle after a rising edge of `vblank_in`. If that edge coincides with a status read, the read returns the old flag and the flag ends cleared.
- R10: After reset the control outputs, scroll values, pointer, read buffer, vertical-blank flag, toggle and sprite address are all zero. `rdata` reads 0 for selects 1, 3, 4, 5 and 6, and when no read is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 3 | Register select |
| wr_en | input | 1 | Write strobe (wins over rd_en) |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the read cycle |
| vblank_in | input | 1 | Vertical-blank level from display timing |
| inc32 | output | 1 | Pointer step of 32 selected |
| nt_sel | output | 2 | Name-table select |
| spr_base | output | 1 | Sprite pattern base select |
| bg_base | output | 1 | Background pattern base select |
| spr_tall | output | 1 | 16-line sprites selected |
| scroll_x | output | 8 | Horizontal scroll |
| scroll_y | output | 8 | Vertical scroll (0..239) |
| scx_coarse | output | 5 | scroll_x >> 3 |
| scx_fine | output | 3 | scroll_x[2:0] |
| scy_coarse | output | 5 | scroll_y >> 3 |
| scy_fine | output | 3 | scroll_y[2:0] |
| vmem_addr | output | 14 | Video memory address (pointer) |
| vmem_wdata | output | 8 | Video memory write data |
| vmem_we | output | 1 | Video memory write enable |
| vmem_re | output | 1 | Video memory read enable |
| vmem_rdata | input | 8 | Video memory read data, one cycle after vmem_re |
| pal_we | output | 32 | Palette per-entry write enables |
| pal_wdata | output | 8 | Palette write data |
| spr_addr | output | 8 | Sprite memory address |
| spr_wdata | output | 8 | Sprite memory write data |
| spr_we | output | 1 | Sprite memory write enable |

## Verification
Scroll decoding is driven with value pairs at zero, just below, at and above the 239 clamp and at full scale. These separate correct clamping from an off-by-one compare, and they show that the coarse and fine splits come from the stored value. The data port is tried with isolated and back-to-back reads, which tell a correct one-read delay from a missing buffer or a missing bypass. Palette writes hit a backdrop address, a normal entry, an ignored entry and a non-palette address, which separates the mirror mask from plain decoding. Toggle tests mix scroll and address writes around status reads to show that the toggle is shared and that status reads reset it.

// File: rtl/vdc_regs.sv
module vdc_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  reg_sel,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic        vblank_in,
  output logic        inc32,
  output logic [1:0]  nt_sel,
  output logic        spr_base,
  output logic        bg_base,
  output logic        spr_tall,
  output logic [7:0]  scroll_x,
  output logic [7:0]  scroll_y,
  output logic [4:0]  scx_coarse,
  output logic [2:0]  scx_fine,
  output logic [4:0]  scy_coarse,
  output logic [2:0]  scy_fine,
  output logic [13:0] vmem_addr,
  output logic [7:0]  vmem_wdata,
  output logic        vmem_we,
  output logic        vmem_re,
  input  logic [7:0]  vmem_rdata,
  output logic [31:0] pal_we,
  output logic [7:0]  pal_wdata,
  output logic [7:0]  spr_addr,
  output logic [7:0]  spr_wdata,
  output logic        spr_we
);

  localparam logic [7:0]  VY_MAX   = 8'd239;
  localparam logic [31:0] BACKDROP = 32'h1111_1111;

  logic [5:0]  ctrl_q;
  logic        vbl_q, vb_prev_q, tog_q, pend_q;
  logic [13:0] ptr_q;
  logic [7:0]  buf_q, sx_q, sy_q, spr_q;

  wire rd     = rd_en & ~wr_en;
  wire st_rd  = rd && reg_sel == 3'd2;
  wire dat_rd = rd && reg_sel == 3'd7;
  wire dat_wr = wr_en && reg_sel == 3'd7;
  wire scr_wr = wr_en && reg_sel == 3'd5;
  wire adr_wr = wr_en && reg_sel == 3'd6;
  wire vb_rise = vblank_in & ~vb_prev_q;
  wire in_pal = &ptr_q[13:8];
  wire [13:0] step = ctrl_q[2] ? 14'd32 : 14'd1;
  wire [7:0] buf_now = pend_q ? vmem_rdata : buf_q;

  assign rdata = st_rd ? {vbl_q, 7'b0} : dat_rd ? buf_now : 8'h00;

  assign nt_sel   = ctrl_q[1:0];
  assign inc32    = ctrl_q[2];
  assign spr_base = ctrl_q[3];
  assign bg_base  = ctrl_q[4];
  assign spr_tall = ctrl_q[5];

  assign scroll_x   = sx_q;
  assign scroll_y   = sy_q;
  assign scx_coarse = sx_q[7:3];
  assign scx_fine   = sx_q[2:0];
  assign scy_coarse = sy_q[7:3];
  assign scy_fine   = sy_q[2:0];

  assign vmem_addr  = ptr_q;
  assign vmem_wdata = wdata;
  assign vmem_we    = dat_wr & ~in_pal;
  assign vmem_re    = dat_rd;

  assign pal_wdata = wdata;
  always_comb begin
    pal_we = '0;
    if (dat_wr && in_pal) begin
      if (ptr_q[3:0] == 4'h0)  pal_we = BACKDROP;
      else if (|ptr_q[1:0])    pal_we = 32'd1 << ptr_q[4:0];
    end
  end

  assign spr_addr  = spr_q;
  assign spr_wdata = wdata;
  assign spr_we    = wr_en && reg_sel == 3'd4;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      vbl_q     <= 1'b0;
      vb_prev_q <= 1'b0;
      tog_q     <= 1'b0;
      pend_q    <= 1'b0;
      ptr_q     <= '0;
      buf_q     <= '0;
      sx_q      <= '0;
      sy_q      <= '0;
      spr_q     <= '0;
    end else begin
      vb_prev_q <= vblank_in;
      if (st_rd)        vbl_q <= 1'b0;
      else if (vb_rise) vbl_q <= 1'b1;

      if (wr_en && reg_sel == 3'd0) ctrl_q <= wdata[5:0];

      if (st_rd)                 tog_q <= 1'b0;
      else if (scr_wr || adr_wr) tog_q <= ~tog_q;

      if (scr_wr) begin
        if (!tog_q) sx_q <= wdata;
        else        sy_q <= (wdata > VY_MAX) ? 8'h00 : wdata;
      end

      if (adr_wr) begin
        if (!tog_q) ptr_q <= {wdata[5:0], 8'h00};
        else        ptr_q <= ptr_q | {6'd0, wdata};
      end else if (dat_rd || dat_wr) begin
        ptr_q <= ptr_q + step;
      end

      pend_q <= dat_rd;
      if (pend_q) buf_q <= vmem_rdata;

      if (wr_en && reg_sel == 3'd3) spr_q <= wdata;
      else if (spr_we)              spr_q <= spr_q + 8'd1;
    end
  end

  AST_STATUS_CLEARS:  assert property (@(posedge clk) disable iff (!rst_n) st_rd |=> (!vbl_q && !tog_q)); // R2
  AST_VSCROLL_RANGE:  assert property (@(posedge clk) disable iff (!rst_n) sy_q <= VY_MAX); // R3
  AST_TOGGLE_FLIP:    assert property (@(posedge clk) disable iff (!rst_n) (scr_wr || adr_wr) |=> tog_q != $past(tog_q)); // R4
  AST_PTR_ADVANCE:    assert property (@(posedge clk) disable iff (!rst_n) (dat_rd || dat_wr) |=> ptr_q == 14'($past(ptr_q) + (($past(ctrl_q[2])) ? 14'd32 : 14'd1))); // R6
  AST_PAL_MASK:       assert property (@(posedge clk) disable iff (!rst_n) ($countones(pal_we) == 0 || $countones(pal_we) == 1 || $countones(pal_we) == 8)); // R7
  AST_PAL_VMEM_EXCL:  assert property (@(posedge clk) disable iff (!rst_n) (pal_we != 32'd0) |-> !vmem_we); // R7
  AST_SPR_ADVANCE:    assert property (@(posedge clk) disable iff (!rst_n) spr_we |=> spr_q == 8'($past(spr_q) + 8'd1)); // R8
  AST_VBL_SET:        assert property (@(posedge clk) disable iff (!rst_n) (vb_rise && !st_rd) |=> vbl_q); // R9

endmodule

// File: tb/vdc_regs_bench.sv
module vdc_regs_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] reg_sel = '0;
  logic wr_en = 1'b0, rd_en = 1'b0, vblank_in = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic inc32, spr_base, bg_base, spr_tall;
  logic [1:0] nt_sel;
  logic [7:0] scroll_x, scroll_y, vmem_wdata, pal_wdata, spr_addr, spr_wdata;
  logic [4:0] scx_coarse, scy_coarse;
  logic [2:0] scx_fine, scy_fine;
  logic [13:0] vmem_addr;
  logic vmem_we, vmem_re, spr_we;
  logic [7:0] vmem_rdata = '0;
  logic [31:0] pal_we;

  int tests = 0, fails = 0;
  logic [7:0] cap_rd;
  logic [31:0] cap_pal;
  logic cap_vwe, cap_swe;
  logic [13:0] cap_vaddr;
  logic [7:0] cap_saddr;

  always #2 clk = ~clk;

  vdc_regs u_vdc_regs (.*);

  function automatic logic [7:0] fmem(input logic [13:0] a);
    return a[7:0] ^ {2'b00, a[13:8]};
  endfunction

  always @(posedge clk) if (vmem_re) vmem_rdata <= fmem(vmem_addr);

  localparam logic [23:0] SCR_VEC [0:4] = '{24'h00_00_00, 24'h7B_EF_EF, 24'hFF_F0_00, 24'h13_FF_00, 24'h08_11_11};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    reg_sel = s; wdata = d; wr_en = 1'b1;
    #1;
    cap_pal = pal_we; cap_vwe = vmem_we; cap_vaddr = vmem_addr;
    cap_swe = spr_we; cap_saddr = spr_addr;
    @(posedge clk); #0.5;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s);
    @(negedge clk);
    reg_sel = s; rd_en = 1'b1;
    #1;
    cap_rd = rdata;
    @(posedge clk); #0.5;
    rd_en = 1'b0;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 ctrl", {27'd0, nt_sel, inc32, spr_base, bg_base, spr_tall}, 32'd0);
    chk("R10 scroll", {16'd0, scroll_x, scroll_y}, 32'd0);
    chk("R10 ptr", {18'd0, vmem_addr}, 32'd0);
    chk("R10 spr", {24'd0, spr_addr}, 32'd0);
    chk("R10 idle rdata", {24'd0, rdata}, 32'd0);
    rd(3'd2); chk("R10 status", {24'd0, cap_rd}, 32'd0);
    rd(3'd5); chk("R10 unread sel", {24'd0, cap_rd}, 32'd0);

    // R3 vector table
    foreach (SCR_VEC[i]) begin
      rd(3'd2);
      wr(3'd5, SCR_VEC[i][23:16]);
      wr(3'd5, SCR_VEC[i][15:8]);
      @(negedge clk);
      chk("R3 x", {24'd0, scroll_x}, {24'd0, SCR_VEC[i][23:16]});
      chk("R3 x split", {24'd0, scx_coarse, scx_fine}, {24'd0, SCR_VEC[i][23:16]});
      chk("R3 y", {24'd0, scroll_y}, {24'd0, SCR_VEC[i][7:0]});
      chk("R3 y split", {24'd0, scy_coarse, scy_fine}, {24'd0, SCR_VEC[i][7:0]});
    end

    // R1 control fields
    wr(3'd0, 8'h27); @(negedge clk);
    chk("R1 a", {27'd0, nt_sel, inc32, spr_base, bg_base, spr_tall}, {27'd0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1});
    wr(3'd0, 8'h18); @(negedge clk);
    chk("R1 b", {27'd0, nt_sel, inc32, spr_base, bg_base, spr_tall}, {27'd0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0});
    wr(3'd0, 8'h00);

    // R4 R5 R6 buffered reads
    rd(3'd2);
    wr(3'd6, 8'h21); wr(3'd6, 8'h08);
    @(negedge clk); chk("R4 ptr", {18'd0, vmem_addr}, 32'h2108);
    rd(3'd7); chk("R5 first read buffer", {24'd0, cap_rd}, 32'h00);
    rd(3'd7); chk("R5 back-to-back", {24'd0, cap_rd}, {24'd0, fmem(14'h2108)});
    rd(3'd7); chk("R5 third", {24'd0, cap_rd}, {24'd0, fmem(14'h2109)});
    @(negedge clk); chk("R6 step1", {18'd0, vmem_addr}, 32'h210B);

    // R7 backdrop mirror, R6 step 32 with wrap
    wr(3'd0, 8'h04);
    rd(3'd2); wr(3'd6, 8'h3F); wr(3'd6, 8'hF0);
    wr(3'd7, 8'h2A);
    chk("R7 backdrop", cap_pal, 32'h1111_1111);
    chk("R7 backdrop no vmem", {31'd0, cap_vwe}, 32'd0);
    @(negedge clk); chk("R6 step32 wrap", {18'd0, vmem_addr}, 32'h0010);
    wr(3'd0, 8'h00);

    rd(3'd2); wr(3'd6, 8'h3F); wr(3'd6, 8'h05);
    wr(3'd7, 8'h11); chk("R7 single", cap_pal, 32'h0000_0020);
    rd(3'd2); wr(3'd6, 8'h3F); wr(3'd6, 8'h04);
    wr(3'd7, 8'h12);
    chk("R7 ignored pal", cap_pal, 32'd0);
    chk("R7 ignored vmem", {31'd0, cap_vwe}, 32'd0);
    @(negedge clk); chk("R6 after ignored", {18'd0, vmem_addr}, 32'h3F05);
    rd(3'd2); wr(3'd6, 8'h01); wr(3'd6, 8'h23);
    wr(3'd7, 8'h13);
    chk("R7 vmem we", {31'd0, cap_vwe}, 32'd1);
    chk("R7 vmem addr", {18'd0, cap_vaddr}, 32'h0123);
    chk("R7 vmem no pal", cap_pal, 32'd0);

    // R4 masking and clearing, shared toggle
    rd(3'd2); wr(3'd6, 8'hFF);
    @(negedge clk); chk("R4 high mask", {18'd0, vmem_addr}, 32'h3F00);
    wr(3'd6, 8'h07);
    @(negedge clk); chk("R4 or low", {18'd0, vmem_addr}, 32'h3F07);
    wr(3'd6, 8'h05);
    @(negedge clk); chk("R4 clears low", {18'd0, vmem_addr}, 32'h0500);
    rd(3'd2); wr(3'd5, 8'h10); wr(3'd6, 8'h22);
    @(negedge clk);
    chk("R4 shared toggle ptr", {18'd0, vmem_addr}, 32'h0522);
    chk("R4 shared toggle x", {24'd0, scroll_x}, 32'h10);

    // R2 status read resets toggle
    wr(3'd5, 8'h33); rd(3'd2); wr(3'd5, 8'h44);
    @(negedge clk); chk("R2 toggle reset", {24'd0, scroll_x}, 32'h44);

    // R8 sprite port
    wr(3'd3, 8'hFE);
    wr(3'd4, 8'hAA);
    chk("R8 we", {31'd0, cap_swe}, 32'd1);
    chk("R8 addr", {24'd0, cap_saddr}, 32'hFE);
    wr(3'd4, 8'hAB); chk("R8 inc", {24'd0, cap_saddr}, 32'hFF);
    wr(3'd4, 8'hAC); chk("R8 wrap", {24'd0, cap_saddr}, 32'h00);

    // R9 vertical blank
    @(negedge clk); vblank_in = 1'b1;
    @(posedge clk);
    rd(3'd2); chk("R9 set", {24'd0, cap_rd}, 32'h80);
    rd(3'd2); chk("R2 cleared", {24'd0, cap_rd}, 32'h00);
    @(negedge clk); vblank_in = 1'b0;
    @(negedge clk);
    reg_sel = 3'd2; rd_en = 1'b1; vblank_in = 1'b1;
    #1 cap_rd = rdata;
    @(posedge clk); #0.5 rd_en = 1'b0;
    chk("R9 same-cycle old", {24'd0, cap_rd}, 32'h00);
    rd(3'd2); chk("R9 ends cleared", {24'd0, cap_rd}, 32'h00);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule